// File: doc/BRIEF.md
# NAND Identification Probe

This block finds out what kind of raw 8-bit NAND device sits on its bus. After a one-cycle start pulse it drives chip enable, the command and address latch enables and the write and read strobes itself. It runs two read-ID passes, one after the other. The first pass sends the read-ID command (0x90) with address 0x00 and reads back five identification bytes. The second pass sends the same command with address 0x20 and reads four bytes. These four bytes are compared against the interface-standard signature, the ASCII text "ONFI".

The fourth identification byte holds the device geometry. From it the probe reports page size and erase-block size as base-2 logarithms. It also reports the five raw bytes and a flag that is set when the signature matched. A one-cycle done pulse marks completion. All results change only in the done cycle, so software or a boot sequencer can read them at any time between runs. The write-strobe width and the read access time are given in clock cycles as parameters.

Top module: `nand_id_probe`

## Requirements
- R1: After reset the probe is idle. Chip enable and both strobes are high, the latch enables and the data-drive enable are low, done and busy are low, the signature flag is 0, the page result is 10, the block result is 16 and the raw bytes are 0.
- R2: A run opens with the first pass. It writes 0x90 with the command latch high, then 0x00 with the address latch high, and then performs five reads. Each written byte is latched by the device on the rising edge of the write strobe.
- R3: The second pass follows the first. It writes 0x90 as a command and 0x20 as an address, then performs four reads. No other bus writes occur in a run.
- R4: Every read holds the read strobe low for exactly RD_CYC cycles. The byte is captured on the clock edge at which the strobe returns high, so data valid only in the last low cycle is taken.
- R5: The raw output carries identification byte k (k = 0..4, in read order) in bits 8k+7:8k.
- R6: The page result equals 10 plus bits 1:0 of byte 3 (1, 2, 4 or 8 KiB).
- R7: The block result equals 16 plus bits 5:4 of byte 3 (64, 128, 256 or 512 KiB).
- R8: The signature flag is 1 only if the four second-pass bytes are 0x4F, 0x4E, 0x46, 0x49 in read order. For the bytes EC DC 10 95 54 the results are page 11, block 17 and flag 0 when the signature is absent.
- R9: Done is high for exactly one cycle per run, with busy already low. The outputs change only in the done cycle and hold until the next done.
- R10: A start pulse while busy has no effect and produces no further run. A start in the done cycle or later begins a new run on the next cycle.
- R11: The command and address latches are never high together. The read and write strobes are never low together. The data-drive enable is low while the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| start_i | input | 1 | start pulse |
| nand_ce_n_o | output | 1 | chip enable, active low |
| nand_cle_o | output | 1 | command latch enable |
| nand_ale_o | output | 1 | address latch enable |
| nand_we_n_o | output | 1 | write strobe, active low |
| nand_re_n_o | output | 1 | read strobe, active low |
| nand_dq_o | output | DW | byte driven to the device |
| nand_dq_oe_o | output | 1 | drive enable for nand_dq_o |
| nand_dq_i | input | DW | byte returned by the device |
| busy_o | output | 1 | run in progress |
| done_o | output | 1 | one-cycle completion pulse |
| id_bytes_o | output | 5*DW | raw identification bytes |
| page_log2_o | output | 4 | log2 of page size in bytes |
| block_log2_o | output | 5 | log2 of erase-block size in bytes |
| std_sig_o | output | 1 | signature matched |

## Verification
The accept path for a new start and the done pulse can fall in the same cycle. A start raised in the very cycle done is high must begin a fresh run, while a start raised in the middle of a run must be dropped. The bench provokes both. It drives start at the falling edge inside the done cycle and then requires busy on the next cycle and a second correct result set. It also injects a stray start partway through several sweep runs and requires that no second done appears within a window longer than a full run. The device model returns a garbage byte except in the last low cycle of each read, so any capture made too early changes the reported bytes.

// File: rtl/nand_idp_pkg.sv
package nand_idp_pkg;

   typedef enum logic [1:0] {OP_CMD, OP_ADR, OP_RD} op_kind_t;
   typedef enum logic [1:0] {E_IDLE, E_LOW, E_HOLD} eng_st_t;

   localparam logic [7:0]  CMD_READ_ID     = 8'h90;
   localparam logic [7:0]  ADR_VENDOR_ID   = 8'h00;
   localparam logic [7:0]  ADR_STD_ID      = 8'h20;
   // signature, first byte read in the low bits: 'O','N','F','I'
   localparam logic [31:0] STD_SIG         = 32'h4946_4E4F;
   localparam int          ID_LEN          = 5;
   localparam int          SIG_LEN         = 4;
   localparam int          GEO_BYTE        = 3;
   localparam int          PAGE_LOG2_BASE  = 10;
   localparam int          BLOCK_LOG2_BASE = 16;

endpackage

// File: rtl/nand_idp_bus.sv
module nand_idp_bus
   import nand_idp_pkg::*;
#(
   parameter int DW     = 8,
   parameter int WE_CYC = 2,
   parameter int RD_CYC = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          op_go,
   input  op_kind_t      op_kind,
   input  logic [DW-1:0] op_data,
   input  logic [DW-1:0] dq_i,
   output logic          op_done,
   output logic [DW-1:0] rd_data,
   output logic          cle,
   output logic          ale,
   output logic          we_n,
   output logic          re_n,
   output logic [DW-1:0] dq_o,
   output logic          dq_oe
);

   localparam int MAXC = (WE_CYC > RD_CYC) ? WE_CYC : RD_CYC;
   localparam int CW   = $clog2(MAXC + 1);

   generate
      if (WE_CYC < 1 || RD_CYC < 1) begin : g_bad_timing
         $error("nand_idp_bus: strobe widths must be at least one cycle");
      end
   endgenerate

   eng_st_t       st_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= E_IDLE;
         cnt_q   <= '0;
         cle     <= 1'b0;
         ale     <= 1'b0;
         we_n    <= 1'b1;
         re_n    <= 1'b1;
         dq_o    <= '0;
         dq_oe   <= 1'b0;
         rd_data <= '0;
      end else begin
         case (st_q)
            E_IDLE: begin
               if (op_go) begin
                  st_q  <= E_LOW;
                  cle   <= (op_kind == OP_CMD);
                  ale   <= (op_kind == OP_ADR);
                  dq_oe <= (op_kind != OP_RD);
                  dq_o  <= op_data;
                  we_n  <= (op_kind == OP_RD);
                  re_n  <= (op_kind != OP_RD);
                  cnt_q <= (op_kind == OP_RD) ? CW'(RD_CYC - 1) : CW'(WE_CYC - 1);
               end
            end
            E_LOW: begin
               if (cnt_q == '0) begin
                  st_q <= E_HOLD;
                  we_n <= 1'b1;
                  re_n <= 1'b1;
                  if (!re_n) rd_data <= dq_i;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            E_HOLD: begin
               st_q  <= E_IDLE;
               cle   <= 1'b0;
               ale   <= 1'b0;
               dq_oe <= 1'b0;
            end
            default: st_q <= E_IDLE;
         endcase
      end
   end

   assign op_done = (st_q == E_HOLD);

   a_r11_latch_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(cle && ale));
   a_r11_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(!we_n && !re_n));
   a_r11_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
      !re_n |-> !dq_oe);
   a_r4_read_held: assert property (@(posedge clk) disable iff (!rst_n)
      (!re_n && cnt_q != '0) |=> !re_n);

endmodule

// File: rtl/nand_idp_decode.sv
module nand_idp_decode
   import nand_idp_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic [DW-1:0]         geo_byte,
   input  logic [SIG_LEN*DW-1:0] sig_bytes,
   output logic [3:0]            page_log2,
   output logic [4:0]            block_log2,
   output logic                  std_ok
);

   generate
      if (DW < 8) begin : g_bad_width
         $error("nand_idp_decode: data width must be at least 8");
      end
   endgenerate

   logic [SIG_LEN-1:0] eq;

   generate
      for (genvar g = 0; g < SIG_LEN; g++) begin : g_sig
         assign eq[g] = (sig_bytes[g*DW +: DW] == DW'(STD_SIG[g*8 +: 8]));
      end
   endgenerate

   assign std_ok     = &eq;
   assign page_log2  = 4'(PAGE_LOG2_BASE)  + 4'(geo_byte[1:0]);
   assign block_log2 = 5'(BLOCK_LOG2_BASE) + 5'(geo_byte[5:4]);

endmodule

// File: rtl/nand_id_probe.sv
module nand_id_probe
   import nand_idp_pkg::*;
#(
   parameter int DW     = 8,
   parameter int WE_CYC = 2,
   parameter int RD_CYC = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   output logic                 nand_ce_n_o,
   output logic                 nand_cle_o,
   output logic                 nand_ale_o,
   output logic                 nand_we_n_o,
   output logic                 nand_re_n_o,
   output logic [DW-1:0]        nand_dq_o,
   output logic                 nand_dq_oe_o,
   input  logic [DW-1:0]        nand_dq_i,
   output logic                 busy_o,
   output logic                 done_o,
   output logic [ID_LEN*DW-1:0] id_bytes_o,
   output logic [3:0]           page_log2_o,
   output logic [4:0]           block_log2_o,
   output logic                 std_sig_o
);

   // op sequence: cmd, adr, ID_LEN reads, cmd, adr, SIG_LEN reads
   localparam int P2    = 2 + ID_LEN;
   localparam int RD1   = 2;
   localparam int RD2   = P2 + 2;
   localparam int N_OPS = P2 + 2 + SIG_LEN;
   localparam int SW    = $clog2(N_OPS + 1);

   logic          run_q, wait_q, done_q;
   logic [SW-1:0] step_q;
   op_kind_t      op_kind;
   logic [DW-1:0] op_data;
   logic          op_go, op_done;
   logic [DW-1:0] rd_data;

   logic [ID_LEN*DW-1:0]  id_cap;
   logic [SIG_LEN*DW-1:0] sig_cap;
   logic [3:0]            dec_page;
   logic [4:0]            dec_block;
   logic                  dec_ok;

   always_comb begin
      op_kind = OP_RD;
      op_data = '0;
      if (step_q == SW'(0) || step_q == SW'(P2)) begin
         op_kind = OP_CMD;
         op_data = DW'(CMD_READ_ID);
      end else if (step_q == SW'(1)) begin
         op_kind = OP_ADR;
         op_data = DW'(ADR_VENDOR_ID);
      end else if (step_q == SW'(P2 + 1)) begin
         op_kind = OP_ADR;
         op_data = DW'(ADR_STD_ID);
      end
   end

   assign op_go = run_q && !wait_q && (step_q != SW'(N_OPS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q        <= 1'b0;
         wait_q       <= 1'b0;
         done_q       <= 1'b0;
         step_q       <= '0;
         id_bytes_o   <= '0;
         page_log2_o  <= 4'(PAGE_LOG2_BASE);
         block_log2_o <= 5'(BLOCK_LOG2_BASE);
         std_sig_o    <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (!run_q) begin
            if (start_i) begin
               run_q  <= 1'b1;
               wait_q <= 1'b0;
               step_q <= '0;
            end
         end else if (step_q == SW'(N_OPS)) begin
            run_q        <= 1'b0;
            done_q       <= 1'b1;
            id_bytes_o   <= id_cap;
            page_log2_o  <= dec_page;
            block_log2_o <= dec_block;
            std_sig_o    <= dec_ok;
         end else if (!wait_q) begin
            wait_q <= 1'b1;
         end else if (op_done) begin
            wait_q <= 1'b0;
            step_q <= step_q + 1'b1;
         end
      end
   end

   generate
      for (genvar g = 0; g < ID_LEN; g++) begin : g_id
         logic [DW-1:0] b_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) b_q <= '0;
            else if (run_q && op_done && step_q == SW'(RD1 + g)) b_q <= rd_data;
         end
         assign id_cap[g*DW +: DW] = b_q;
      end
      for (genvar g = 0; g < SIG_LEN; g++) begin : g_sg
         logic [DW-1:0] b_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) b_q <= '0;
            else if (run_q && op_done && step_q == SW'(RD2 + g)) b_q <= rd_data;
         end
         assign sig_cap[g*DW +: DW] = b_q;
      end
   endgenerate

   nand_idp_bus #(.DW(DW), .WE_CYC(WE_CYC), .RD_CYC(RD_CYC)) bus_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .op_go   (op_go),
      .op_kind (op_kind),
      .op_data (op_data),
      .dq_i    (nand_dq_i),
      .op_done (op_done),
      .rd_data (rd_data),
      .cle     (nand_cle_o),
      .ale     (nand_ale_o),
      .we_n    (nand_we_n_o),
      .re_n    (nand_re_n_o),
      .dq_o    (nand_dq_o),
      .dq_oe   (nand_dq_oe_o)
   );

   nand_idp_decode #(.DW(DW)) dec_i (
      .geo_byte   (id_cap[GEO_BYTE*DW +: DW]),
      .sig_bytes  (sig_cap),
      .page_log2  (dec_page),
      .block_log2 (dec_block),
      .std_ok     (dec_ok)
   );

   assign nand_ce_n_o = !run_q;
   assign busy_o      = run_q;
   assign done_o      = done_q;

   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   a_r9_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);
   a_r9_page_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(page_log2_o) |-> done_o);
   a_r9_bytes_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(id_bytes_o) |-> done_o);
   a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i && step_q != SW'(N_OPS)) |=> busy_o);
   a_r6_page_range: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (page_log2_o >= 4'd10 && page_log2_o <= 4'd13));
   a_r7_block_range: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (block_log2_o >= 5'd16 && block_log2_o <= 5'd19));

endmodule

// File: tb/nand_id_probe_tb_top.sv
module nand_id_probe_tb_top;

   localparam int WE_CYC = 2;
   localparam int RD_CYC = 3;
   localparam logic [31:0] SIG_OK = 32'h4946_4E4F;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   always #5 clk = ~clk;

   logic        ce_n, cle, ale, we_n, re_n, oe, busy, done, sig_ok;
   logic [7:0]  dq_o;
   logic [7:0]  dq_i = 8'hA5;
   logic [39:0] idb;
   logic [3:0]  pg;
   logic [4:0]  bk;

   nand_id_probe #(.DW(8), .WE_CYC(WE_CYC), .RD_CYC(RD_CYC)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start),
      .nand_ce_n_o(ce_n), .nand_cle_o(cle), .nand_ale_o(ale),
      .nand_we_n_o(we_n), .nand_re_n_o(re_n), .nand_dq_o(dq_o),
      .nand_dq_oe_o(oe), .nand_dq_i(dq_i), .busy_o(busy), .done_o(done),
      .id_bytes_o(idb), .page_log2_o(pg), .block_log2_o(bk), .std_sig_o(sig_ok)
   );

   int n_chk = 0;
   int n_fail = 0;

   // device model, evaluated at falling edges
   logic [39:0] id_m  = '0;
   logic [31:0] sig_m = '0;
   logic [7:0]  addr_m = 8'hFF;
   int idx_m = 0, low_m = 0, rd_n = 0, rd_bad = 0, wlog_n = 0, excl_bad = 0;
   logic prev_we = 1'b1, prev_re = 1'b1;
   logic [9:0] wlog [16];

   function automatic logic [7:0] model_byte();
      if (addr_m == 8'h00) return (idx_m < 5) ? id_m[idx_m*8 +: 8] : 8'h00;
      if (addr_m == 8'h20) return (idx_m < 4) ? sig_m[idx_m*8 +: 8] : 8'h00;
      return 8'hFF;
   endfunction

   always @(negedge clk) begin
      if (!prev_we && we_n) begin
         if (wlog_n < 16) wlog[wlog_n] = {cle, ale, dq_o};
         wlog_n++;
         if (ale) begin addr_m = dq_o; idx_m = 0; end
      end
      if (!prev_re && re_n) begin
         rd_n++;
         if (low_m != RD_CYC) rd_bad++;
         idx_m++;
         low_m = 0;
      end
      if (!re_n) low_m++;
      if ((cle && ale) || (!we_n && !re_n) || (!re_n && oe)) excl_bad++;
      prev_we = we_n;
      prev_re = re_n;
      dq_i = (!re_n && low_m >= RD_CYC) ? model_byte() : 8'hA5;
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // one run; pre_started: start was already given; chain: start next run in done cycle
   task automatic run(input logic [39:0] idv, input logic [31:0] sgv,
                      input bit inject, input bit pre_started, input bit chain);
      int t;
      int extra;
      logic [39:0] held;
      id_m = idv; sig_m = sgv;
      wlog_n = 0; rd_n = 0; rd_bad = 0;
      if (!pre_started) begin
         @(negedge clk); start = 1'b1;
         @(negedge clk); start = 1'b0;
         chk("R10 start accepted when idle", busy, 1);
      end
      t = 0;
      while (!done && t < 3000) begin
         @(negedge clk);
         t++;
         start = (inject && t == 20);
      end
      start = 1'b0;
      chk("R9 done reached", done, 1);
      chk("R9 busy low at done", busy, 0);
      chk("R5 raw id bytes", idb, idv);
      chk("R6 page log2", pg, 4'(10 + idv[25:24]));
      chk("R7 block log2", bk, 5'(16 + idv[29:28]));
      chk("R8 signature flag", sig_ok, (sgv == SIG_OK));
      chk("R2 first pass writes", {wlog[0], wlog[1]}, {2'b10, 8'h90, 2'b01, 8'h00});
      chk("R3 second pass writes", {wlog[2], wlog[3]}, {2'b10, 8'h90, 2'b01, 8'h20});
      chk("R3 write count", wlog_n, 4);
      chk("R4 read count", rd_n, 9);
      chk("R4 read strobe width", rd_bad, 0);
      held = idb;
      if (chain) begin
         start = 1'b1;
         @(negedge clk); start = 1'b0;
         chk("R10 start in done cycle accepted", busy, 1);
      end else begin
         @(negedge clk);
         chk("R9 done one cycle", done, 0);
         extra = 0;
         for (int k = 0; k < 150; k++) begin
            @(negedge clk);
            if (done) extra++;
         end
         chk(inject ? "R10 busy start ignored" : "R9 single done", extra, 0);
         chk("R9 outputs held", idb, held);
      end
   endtask

   initial begin
      #1_500_000;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset pins", {ce_n, we_n, re_n, cle, ale, oe, done, busy, sig_ok}, 9'b111000000);
      chk("R1 reset results", {pg, bk, idb}, {4'd10, 5'd16, 40'd0});
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 idle after reset", busy, 0);

      // reference device, no signature
      run({8'h54, 8'h95, 8'h10, 8'hDC, 8'hEC}, 32'h0, 1'b0, 1'b0, 1'b0);
      chk("R8 reference page", pg, 11);
      chk("R8 reference block", bk, 17);
      chk("R8 reference flag", sig_ok, 0);

      // sweep both geometry fields; alternate matching and near-miss signatures
      for (int f = 0; f < 16; f++) begin
         logic [3:0]  fv;
         logic [7:0]  b3;
         logic [39:0] idv;
         logic [31:0] sgv;
         fv  = 4'(f);
         b3  = {2'b10, fv[3:2], 2'b01, fv[1:0]};
         idv = {8'h40 + 8'(f), b3, 8'(f * 3), 8'hD0 ^ 8'(f), 8'h20 + 8'(f)};
         sgv = (f % 2 == 0) ? SIG_OK : (SIG_OK ^ (32'h20 << (8 * ((f / 2) % 4))));
         run(idv, sgv, (f % 3 == 0), 1'b0, 1'b0);
      end

      // start raised in the done cycle chains into a second run
      run({8'h11, 8'h33, 8'h22, 8'h01, 8'h98}, SIG_OK, 1'b0, 1'b0, 1'b1);
      run({8'h07, 8'h20, 8'h5A, 8'hC3, 8'h2C}, 32'h4946_4E6F, 1'b0, 1'b1, 1'b0);

      chk("R11 strobe and latch exclusivity", excl_bad, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule